// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block turns parallel left and right audio samples into a single serial data line. It sends each 24-bit sample most significant bit first, so a receiver may keep as many leading bits as it needs and ignore the rest. The bit clock and the framing clock both come from outside the block. They are sampled into the local system clock domain, and the data line is driven from there.

Three static selects set the framing. The first chooses the reference: a left/right clock, or a word clock whose rising edge marks the frame. The second places the first bit either at the framing edge or one bit clock after it. The third picks which bit-clock edge moves the data, so that a receiver capturing on the other edge sees a settled line. A new sample pair is offered with a one-cycle strobe and waits in a holding register. It is taken into use only when the next frame starts. If nothing new arrives, the previous pair is sent again.

Top module: `srtx_top`

## Requirements
- R1: Every word is 24 bits, sent MSB first. One bit goes out per drive edge of the bit clock, and the line changes no more than once per drive edge.
- R2: With cfgWordClk=0, a falling edge of frameClkIn starts the left word and a rising edge starts the right word. The framing clock is low during the left half of the frame.
- R3: With cfgWordClk=1, a rising edge of frameClkIn starts the left word. The right word follows with no gap, on the drive edge after the left LSB.
- R4: With cfgDelay=0, the MSB is driven on the same drive edge that first shows the framing edge. With cfgDelay=1, it is driven one bit clock later.
- R5: With cfgDriveRise=1, sdOut changes only after rising bit-clock edges. With cfgDriveRise=0, it changes only after falling edges. Data is correct when captured on the opposite edge.
- R6: After the LSB of a word, sdOut is held low until the next word starts.
- R7: A pair offered with sampleValid is used from the next left-word start. A pair offered in the middle of a frame does not change the current frame.
- R8: If no new pair has been offered by the time a frame starts, the previous pair is sent again.
- R9: While rstN is low, sdOut is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWordClk | input | 1 | 0: left/right clock framing, 1: word clock rising-edge framing |
| cfgDelay | input | 1 | 1: first bit one bit clock after the framing edge |
| cfgDriveRise | input | 1 | 1: data moves on rising bit-clock edges, 0: on falling edges |
| sampleLeft | input | 24 | Left sample offered |
| sampleRight | input | 24 | Right sample offered |
| sampleValid | input | 1 | One-cycle strobe that captures the offered pair |
| bitClkIn | input | 1 | External bit clock |
| frameClkIn | input | 1 | External left/right clock or word clock |
| sdOut | output | 1 | Serial data out |

## Verification
A counter or arm flag that goes wrong inside the block appears on the data line within one frame. A counter that is off by one cuts a word short or shifts it a slot, which shows up as a one-bit displacement of the captured word. A lost delay flag moves the whole word one bit earlier. A stale hold register repeats the old pair one frame too long. A wrong edge choice makes the line change just before the receiver captures, and a receiver capturing on the opposite edge then reads garbage on the very next bit.

// File: rtl/srtx_pkg.sv
package srtx_pkg;
  // Strobes from control to datapath; at most one of the four actions per drive edge.
  typedef struct packed {
    logic driveEdge;
    logic latchFrame;
    logic loadLeft;
    logic loadRight;
    logic shiftOut;
    logic idleOut;
  } txStrobe_t;
endpackage

// File: rtl/srtx_ctrl.sv
module srtx_ctrl
  import srtx_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWordClk,
  input  logic       cfgDelay,
  input  logic       cfgDriveRise,
  input  logic       bitClkIn,
  input  logic       frameClkIn,
  output txStrobe_t  strb
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam int TOP   = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] bitSync;
  logic [SYNC_STAGES-1:0] frameSync;
  logic                   bitPrev;
  logic                   frameLast;
  logic [CNT_W-1:0]       bitsLeft;
  logic                   armed;
  logic                   armRight;
  logic                   rightPend;

  logic bitNow, frameNow, driveEdge, startLeft, startRight;

  // Bit clock and framing clock pass through matching chains so they stay aligned.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitSync   <= '0;
      frameSync <= '0;
      bitPrev   <= 1'b0;
    end else begin
      bitSync   <= {bitSync[TOP-1:0], bitClkIn};
      frameSync <= {frameSync[TOP-1:0], frameClkIn};
      bitPrev   <= bitSync[TOP];
    end
  end

  assign bitNow    = bitSync[TOP];
  assign frameNow  = frameSync[TOP];
  assign driveEdge = (bitNow != bitPrev) && (bitNow == cfgDriveRise);

  // Framing decode: level seen at this drive edge against the level at the last one.
  assign startLeft  = driveEdge && (cfgWordClk ? (frameNow && !frameLast)
                                               : (!frameNow && frameLast));
  assign startRight = driveEdge && !cfgWordClk && frameNow && !frameLast;

  always_comb begin
    strb           = '0;
    strb.driveEdge = driveEdge;
    if (driveEdge) begin
      strb.latchFrame = startLeft;
      if (!cfgDelay && startLeft)       strb.loadLeft  = 1'b1;
      else if (!cfgDelay && startRight) strb.loadRight = 1'b1;
      else if (armed) begin
        if (armRight) strb.loadRight = 1'b1;
        else          strb.loadLeft  = 1'b1;
      end
      else if (bitsLeft != '0)          strb.shiftOut  = 1'b1;
      else if (rightPend)               strb.loadRight = 1'b1;
      else                              strb.idleOut   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameLast <= 1'b0;
      bitsLeft  <= '0;
      armed     <= 1'b0;
      armRight  <= 1'b0;
      rightPend <= 1'b0;
    end else if (driveEdge) begin
      frameLast <= frameNow;
      armed     <= cfgDelay && (startLeft || startRight);
      armRight  <= startRight;
      if (strb.loadLeft || strb.loadRight) bitsLeft <= CNT_W'(WORD_W - 1);
      else if (strb.shiftOut)              bitsLeft <= bitsLeft - 1'b1;
      if (strb.loadLeft && cfgWordClk) rightPend <= 1'b1;
      else if (strb.loadRight)         rightPend <= 1'b0;
    end
  end
endmodule

// File: rtl/srtx_datapath.sv
module srtx_datapath
  import srtx_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strb,
  input  logic [WORD_W-1:0] sampleLeft,
  input  logic [WORD_W-1:0] sampleRight,
  input  logic              sampleValid,
  output logic [WORD_W-1:0] curLeft,
  output logic [WORD_W-1:0] curRight,
  output logic              sdOut
);
  logic [WORD_W-1:0] pendLeft, pendRight, shiftReg;
  logic              pendValid;
  logic [WORD_W-1:0] wordLeft, wordRight;
  logic              takePend;

  assign takePend  = strb.latchFrame && pendValid;
  assign wordLeft  = takePend ? pendLeft  : curLeft;
  assign wordRight = takePend ? pendRight : curRight;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendLeft  <= '0;
      pendRight <= '0;
      pendValid <= 1'b0;
      curLeft   <= '0;
      curRight  <= '0;
    end else begin
      if (sampleValid) begin
        pendLeft  <= sampleLeft;
        pendRight <= sampleRight;
        pendValid <= 1'b1;
      end else if (strb.latchFrame) begin
        pendValid <= 1'b0;
      end
      if (takePend) begin
        curLeft  <= pendLeft;
        curRight <= pendRight;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      sdOut    <= 1'b0;
    end else if (strb.loadLeft) begin
      sdOut    <= wordLeft[WORD_W-1];
      shiftReg <= wordLeft << 1;
    end else if (strb.loadRight) begin
      sdOut    <= wordRight[WORD_W-1];
      shiftReg <= wordRight << 1;
    end else if (strb.shiftOut) begin
      sdOut    <= shiftReg[WORD_W-1];
      shiftReg <= shiftReg << 1;
    end else if (strb.idleOut) begin
      sdOut    <= 1'b0;
    end
  end
endmodule

// File: rtl/srtx_top.sv
module srtx_top
  import srtx_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWordClk,
  input  logic              cfgDelay,
  input  logic              cfgDriveRise,
  input  logic [WORD_W-1:0] sampleLeft,
  input  logic [WORD_W-1:0] sampleRight,
  input  logic              sampleValid,
  input  logic              bitClkIn,
  input  logic              frameClkIn,
  output logic              sdOut
);
  txStrobe_t         strb;
  logic [WORD_W-1:0] curLeft, curRight;

  srtx_ctrl #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWordClk(cfgWordClk), .cfgDelay(cfgDelay),
    .cfgDriveRise(cfgDriveRise), .bitClkIn(bitClkIn), .frameClkIn(frameClkIn),
    .strb(strb)
  );

  srtx_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sampleLeft(sampleLeft),
    .sampleRight(sampleRight), .sampleValid(sampleValid),
    .curLeft(curLeft), .curRight(curRight), .sdOut(sdOut)
  );
endmodule

// File: rtl/srtx_chk.sv
module srtx_chk
  import srtx_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input txStrobe_t         strb,
  input logic              sdOut,
  input logic [WORD_W-1:0] curLeft,
  input logic [WORD_W-1:0] curRight
);
  // R5
  sd_change_on_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdOut) |-> $past(strb.driveEdge));

  // R1
  one_action_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.driveEdge |-> ($countones({strb.loadLeft, strb.loadRight, strb.shiftOut, strb.idleOut}) == 1));

  // R1
  no_action_off_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.driveEdge |-> !(strb.loadLeft || strb.loadRight || strb.shiftOut || strb.idleOut || strb.latchFrame));

  // R6
  idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.idleOut |=> !sdOut);

  // R7
  cur_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({curLeft, curRight}) |-> $past(strb.latchFrame));

  // R9
  reset_low_chk: assert property (@(posedge clk)
    !rstN |-> !sdOut);
endmodule

bind srtx_top srtx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rstN(rstN), .strb(strb), .sdOut(sdOut),
  .curLeft(curLeft), .curRight(curRight)
);

// File: tb/srtx_top_bench.sv
module srtx_top_bench;
  typedef struct packed {
    logic        wc;
    logic        dly;
    logic        rise;
    logic [23:0] l;
    logic [23:0] r;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 1'b1, 24'hA5C3F1, 24'h3C0F96},
    '{1'b0, 1'b1, 1'b1, 24'h800001, 24'hFFFFFF},
    '{1'b1, 1'b0, 1'b1, 24'h123456, 24'hFEDCBA},
    '{1'b1, 1'b1, 1'b0, 24'hFFFFFF, 24'h000001},
    '{1'b0, 1'b0, 1'b0, 24'h5A5A5A, 24'hC00003},
    '{1'b0, 1'b1, 1'b0, 24'h0F0F0F, 24'h7FFFFE}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWordClk = 1'b0, cfgDelay = 1'b0, cfgDriveRise = 1'b1;
  logic [23:0] sampleLeft = '0, sampleRight = '0;
  logic sampleValid = 1'b0;
  logic bitClk = 1'b0, frameClk = 1'b0;
  logic sdOut;
  logic [63:0] cap;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  srtx_top u_srtx_top (
    .clk(clk), .rstN(rstN), .cfgWordClk(cfgWordClk), .cfgDelay(cfgDelay),
    .cfgDriveRise(cfgDriveRise), .sampleLeft(sampleLeft), .sampleRight(sampleRight),
    .sampleValid(sampleValid), .bitClkIn(bitClk), .frameClkIn(frameClk), .sdOut(sdOut)
  );

  task automatic check(input string tag, input logic [23:0] got, input logic [23:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic loadPair(input logic [23:0] l, input logic [23:0] r);
    @(negedge clk);
    sampleLeft = l; sampleRight = r; sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  // Plays one 64-slot frame as the external clock source; captures sdOut at each capture edge.
  task automatic runFrame(input logic wc, input logic rise, input int pulseSlot,
                          input logic [23:0] pl, input logic [23:0] pr);
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      bitClk   = rise;
      frameClk = wc ? (k == 0) : (k >= 32);
      if (k == pulseSlot) begin
        sampleLeft = pl; sampleRight = pr; sampleValid = 1'b1;
        @(negedge clk);
        sampleValid = 1'b0;
        repeat (5) @(negedge clk);
      end else begin
        repeat (6) @(negedge clk);
      end
      cap[k] = sdOut;
      bitClk = ~rise;
      repeat (5) @(negedge clk);
    end
  endtask

  task automatic checkFrame(input string tag, input logic wc, input logic dly,
                            input logic [23:0] l, input logic [23:0] r, input bit zeroChk);
    logic [23:0] gotL, gotR;
    logic [63:0] mask;
    int offL, offR;
    offL = int'(dly);
    offR = wc ? 24 + int'(dly) : 32 + int'(dly);
    mask = '0;
    for (int i = 0; i < 24; i++) begin
      gotL[23-i] = cap[offL+i];
      gotR[23-i] = cap[offR+i];
      mask[offL+i] = 1'b1;
      mask[offR+i] = 1'b1;
    end
    check({"R1 left ", tag}, gotL, l);
    check({"R1 right ", tag}, gotR, r);
    if (zeroChk) check({"R6 gap low ", tag}, 24'(($countones(cap & ~mask)) != 0), 24'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 sdOut in reset", 24'(sdOut), 24'h0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      string tag;
      tag = $sformatf("vec%0d %s %s %s", v, VECS[v].wc ? "R3" : "R2",
                      VECS[v].dly ? "R4 delayed" : "R4 aligned",
                      VECS[v].rise ? "R5 rise" : "R5 fall");
      @(negedge clk);
      cfgWordClk = VECS[v].wc; cfgDelay = VECS[v].dly; cfgDriveRise = VECS[v].rise;
      loadPair(VECS[v].l, VECS[v].r);
      runFrame(VECS[v].wc, VECS[v].rise, -1, '0, '0);
      runFrame(VECS[v].wc, VECS[v].rise, -1, '0, '0);
      checkFrame(tag, VECS[v].wc, VECS[v].dly, VECS[v].l, VECS[v].r, 1'b1);
    end

    // R7: pair offered mid-frame leaves the current frame unchanged
    runFrame(VECS[NVEC-1].wc, VECS[NVEC-1].rise, 40, 24'h9E3779, 24'h2468AC);
    checkFrame("R7 mid-frame hold", VECS[NVEC-1].wc, VECS[NVEC-1].dly,
               VECS[NVEC-1].l, VECS[NVEC-1].r, 1'b0);
    // R7: used from the next frame start
    runFrame(VECS[NVEC-1].wc, VECS[NVEC-1].rise, -1, '0, '0);
    checkFrame("R7 next frame", VECS[NVEC-1].wc, VECS[NVEC-1].dly,
               24'h9E3779, 24'h2468AC, 1'b0);
    // R8: nothing new offered, pair repeats
    runFrame(VECS[NVEC-1].wc, VECS[NVEC-1].rise, -1, '0, '0);
    checkFrame("R8 repeat", VECS[NVEC-1].wc, VECS[NVEC-1].dly,
               24'h9E3779, 24'h2468AC, 1'b1);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule